// File: doc/BRIEF.md
# Redundant Memory Access Suppressor

This block sits in front of a single-port synchronous SRAM. Each cycle it decides whether the memory has to be enabled at all. It drops the chip select for any access whose effect nobody could observe:

- a write that repeats, in the very next cycle, the same address and the same data;
- a read that repeats, in the very next cycle, the same address;
- a write whose data-valid qualifier is low.

The memory model registers its read data, and that data changes only on an enabled read. A read that is suppressed therefore still presents the correct word, and downstream logic sees a value that does not move.

A one-entry history holds the previous cycle's kind of access, its address and its write data. A repeat is recognised only against an unbroken run of identical accesses. Each of the following clears the history:

- reset;
- an idle cycle;
- a dropped invalid write.

A change between read and write replaces the history, so a read is never merged across an intervening write. A saturating counter reports how many request cycles were kept away from the array.

Top module: `mem_access_gate`

## Requirements
- R1: After synchronous reset the suppression count and the read data are zero. The history is empty, so the first valid access enables the memory.
- R2: A valid write (req_en=1, req_we=1, req_valid=1) whose address and data equal those of a valid write in the previous cycle leaves mem_cs low. The array is unchanged.
- R3: A valid write that differs from the previous cycle's write in address or data drives mem_cs high.
- R4: A read (req_en=1, req_we=0) at the same address as a read in the previous cycle leaves mem_cs low.
- R5: A write with req_valid=0 never drives mem_cs high and never alters the array. It also clears the history, so an identical valid write that follows is enabled.
- R6: An idle cycle (req_en=0) clears the history. Identical accesses separated by an idle cycle are each enabled.
- R7: A write between two reads of one address breaks the read-repeat match. The second read is enabled and returns the newly written data.
- R8: rd_data changes only in the cycle after an enabled read, and holds its value otherwise.
- R9: suppress_cnt increments by one for every cycle with req_en=1 and mem_cs low. It saturates at its all-ones value.
- R10: One cycle after an enabled or suppressed read, rd_data equals the data of the latest valid write to that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_en | input | 1 | Access request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| req_valid | input | 1 | Write data qualifier |
| mem_cs | output | 1 | Chip select actually applied to the array |
| rd_data | output | DATA_W | Registered read data |
| suppress_cnt | output | CNT_W | Saturating count of suppressed request cycles |

## Verification
The hardest situations to reach are those where history must be broken or kept across a run of accesses. Examples are an invalid write squeezed between two identical valid writes, a write sandwiched between two reads of one address, and counter saturation after a long run of repeats. The bench builds these as directed sequences. It then runs a random stream over a four-word address window with a narrow data range, so that repeats, breaks and type flips arise densely. Every cycle is compared against a behavioural memory and history model.

// File: rtl/gate_pkg.sv
package gate_pkg;

    typedef enum logic [1:0] {
        K_IDLE  = 2'd0,
        K_READ  = 2'd1,
        K_WRITE = 2'd2,
        K_DROP  = 2'd3
    } req_kind_e;

    function automatic req_kind_e classify(input logic en, input logic we, input logic valid);
        if (!en)        return K_IDLE;
        else if (!we)   return K_READ;
        else if (valid) return K_WRITE;
        else            return K_DROP;
    endfunction

endpackage

// File: rtl/gate_history.sv
module gate_history
    import gate_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  req_kind_e         kind,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              repeat_hit
);
    typedef struct packed {
        logic              vld;
        logic              is_wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } hist_t;

    hist_t hist_q, hist_d;

    always_comb begin
        repeat_hit = 1'b0;
        if (hist_q.vld && hist_q.addr == addr) begin
            unique case (kind)
                K_READ:  repeat_hit = !hist_q.is_wr;
                K_WRITE: repeat_hit = hist_q.is_wr && hist_q.data == wdata;
                default: repeat_hit = 1'b0;
            endcase
        end
    end

    always_comb begin
        hist_d       = '0;
        hist_d.vld   = (kind == K_READ) || (kind == K_WRITE);
        hist_d.is_wr = (kind == K_WRITE);
        hist_d.addr  = addr;
        hist_d.data  = wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) hist_q <= '0;
        else     hist_q <= hist_d;
    end
endmodule

// File: rtl/gate_sram.sv
module gate_sram #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] array_q [DEPTH];

    always_ff @(posedge clk) begin
        if (cs && we) array_q[addr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst)              rdata <= '0;
        else if (cs && !we)   rdata <= array_q[addr];
    end
endmodule

// File: rtl/gate_sat_cnt.sv
module gate_sat_cnt #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    always_ff @(posedge clk) begin
        if (rst)                         count <= '0;
        else if (inc && count != CNT_MAX) count <= count + 1'b1;
    end
endmodule

// File: rtl/mem_access_gate.sv
module mem_access_gate
    import gate_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_en,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              req_valid,
    output logic              mem_cs,
    output logic [DATA_W-1:0] rd_data,
    output logic [CNT_W-1:0]  suppress_cnt
);
    req_kind_e kind;
    logic      repeat_hit;
    logic      useful;

    assign kind   = classify(req_en, req_we, req_valid);
    assign useful = (kind == K_READ) || (kind == K_WRITE);
    assign mem_cs = useful && !repeat_hit && !rst;

    gate_history #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_hist (
        .clk        (clk),
        .rst        (rst),
        .kind       (kind),
        .addr       (req_addr),
        .wdata      (req_wdata),
        .repeat_hit (repeat_hit)
    );

    gate_sram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_sram (
        .clk   (clk),
        .rst   (rst),
        .cs    (mem_cs),
        .we    (req_we),
        .addr  (req_addr),
        .wdata (req_wdata),
        .rdata (rd_data)
    );

    gate_sat_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .inc   (req_en && !mem_cs),
        .count (suppress_cnt)
    );
endmodule

// File: rtl/gate_checker.sv
module gate_checker #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              req_en,
    input logic              req_we,
    input logic [ADDR_W-1:0] req_addr,
    input logic [DATA_W-1:0] req_wdata,
    input logic              req_valid,
    input logic              mem_cs,
    input logic [DATA_W-1:0] rd_data,
    input logic [CNT_W-1:0]  suppress_cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    assert_drop_invalid_R5: assert property (@(posedge clk) disable iff (rst)
        (req_en && req_we && !req_valid) |-> !mem_cs);

    assert_repeat_write_R2: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && req_en && req_we && req_valid &&
         $past(req_en && req_we && req_valid) &&
         req_addr == $past(req_addr) && req_wdata == $past(req_wdata)) |-> !mem_cs);

    assert_repeat_read_R4: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && req_en && !req_we && $past(req_en && !req_we) &&
         req_addr == $past(req_addr)) |-> !mem_cs);

    assert_after_idle_R6: assert property (@(posedge clk) disable iff (rst)
        ($past(!req_en) && req_en && !(req_we && !req_valid)) |-> mem_cs);

    assert_rdata_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !($past(mem_cs) && !$past(req_we)) |-> $stable(rd_data));

    assert_count_step_R9: assert property (@(posedge clk) disable iff (rst)
        (req_en && !mem_cs && suppress_cnt != CNT_MAX) |=>
        suppress_cnt == $past(suppress_cnt) + 1'b1);

    assert_count_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (!(req_en && !mem_cs)) |=> $stable(suppress_cnt));
endmodule

bind mem_access_gate gate_checker #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .req_en       (req_en),
    .req_we       (req_we),
    .req_addr     (req_addr),
    .req_wdata    (req_wdata),
    .req_valid    (req_valid),
    .mem_cs       (mem_cs),
    .rd_data      (rd_data),
    .suppress_cnt (suppress_cnt)
);

// File: tb/mem_access_gate_tb.sv
module mem_access_gate_tb;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 4;
    localparam int DW = 8;
    localparam int CW = 4;
    localparam int DEPTH = 1 << AW;
    localparam int CMAX = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_en = 1'b0, req_we = 1'b0, req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          mem_cs;
    logic [DW-1:0] rd_data;
    logic [CW-1:0] suppress_cnt;

    int checks = 0;
    int errors = 0;

    int  m_mem [DEPTH];
    bit  h_vld, h_wr;
    int  h_addr, h_data;
    int  exp_rd, exp_cnt;

    always #(CLK_PERIOD/2) clk = ~clk;

    mem_access_gate #(.ADDR_W(AW), .DATA_W(DW), .CNT_W(CW)) u_dut (
        .clk(clk), .rst(rst), .req_en(req_en), .req_we(req_we),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_valid(req_valid),
        .mem_cs(mem_cs), .rd_data(rd_data), .suppress_cnt(suppress_cnt)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic step(input bit en, input bit we, input int addr, input int data,
                        input bit valid, input string req);
        bit exp_cs;
        @(negedge clk);
        req_en = en; req_we = we; req_addr = AW'(addr);
        req_wdata = DW'(data); req_valid = valid;
        #1;
        if (!en)               exp_cs = 0;
        else if (!we)          exp_cs = !(h_vld && !h_wr && h_addr == addr);
        else if (valid)        exp_cs = !(h_vld && h_wr && h_addr == addr && h_data == data);
        else                   exp_cs = 0;
        check(req, "mem_cs", int'(mem_cs), int'(exp_cs));
        @(posedge clk);
        #1;
        if (en && !we)          exp_rd = m_mem[addr];
        if (en && we && valid)  m_mem[addr] = data;
        if (en && (!we || valid)) begin
            h_vld = 1; h_wr = we; h_addr = addr; h_data = data;
        end else begin
            h_vld = 0;
        end
        if (en && !exp_cs && exp_cnt < CMAX) exp_cnt++;
        check(req, "rd_data", int'(rd_data), exp_rd);
        check("R9", "suppress_cnt", int'(suppress_cnt), exp_cnt);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        h_vld = 0; exp_rd = 0; exp_cnt = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check("R1", "suppress_cnt after reset", int'(suppress_cnt), 0);
        check("R1", "rd_data after reset", int'(rd_data), 0);

        // R1 / R10: fill the array, first access enabled
        for (int i = 0; i < DEPTH; i++) step(1, 1, i, (i * 17 + 3) & 8'hFF, 1, "R10");
        for (int i = 0; i < 4; i++) step(1, 0, i, 0, 0, "R10");

        // R2: identical writes merged
        step(1, 1, 5, 8'h5A, 1, "R3");
        step(1, 1, 5, 8'h5A, 1, "R2");
        step(1, 1, 5, 8'h5A, 1, "R2");
        // R3: data or address differs
        step(1, 1, 5, 8'h5B, 1, "R3");
        step(1, 1, 6, 8'h5B, 1, "R3");

        // R4 / R8 / R10: repeated reads
        step(1, 0, 5, 0, 0, "R10");
        step(1, 0, 5, 0, 0, "R4");
        step(1, 0, 5, 0, 0, "R8");
        step(1, 0, 6, 0, 0, "R10");

        // R5: invalid write dropped, array unchanged, history cleared
        step(1, 1, 6, 8'hEE, 0, "R5");
        step(1, 0, 6, 0, 0, "R5");
        step(1, 1, 7, 8'h33, 1, "R3");
        step(1, 1, 7, 8'h33, 0, "R5");
        step(1, 1, 7, 8'h33, 1, "R5");

        // R6: idle between identical accesses
        step(1, 0, 6, 0, 0, "R6");
        step(0, 0, 6, 0, 0, "R6");
        step(1, 0, 6, 0, 0, "R6");
        step(1, 1, 6, 8'h44, 1, "R6");
        step(0, 1, 6, 8'h44, 1, "R6");
        step(1, 1, 6, 8'h44, 1, "R6");

        // R7: write between reads of one address
        step(1, 0, 7, 0, 0, "R7");
        step(1, 1, 7, 8'h99, 1, "R7");
        step(1, 0, 7, 0, 0, "R7");
        step(1, 0, 7, 0, 0, "R4");

        // R9: saturation
        for (int i = 0; i < 20; i++) step(1, 0, 7, 0, 0, "R9");

        // mixed random stream
        for (int i = 0; i < 400; i++) begin
            int r;
            r = int'($urandom_range(0, 9));
            step(r != 0, r < 5, int'($urandom_range(0, 3)), int'($urandom_range(0, 2)),
                 r != 4, "R10");
        end

        step(0, 0, 0, 0, 0, "R8");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule